// File: doc/BRIEF.md
# System Interrupt Mask-and-Route Unit

This unit is the system-wide half of a multiprocessor interrupt controller. Thirty-two level-sensitive device lines come in. A transition on any line is recorded in a system pending register. Software owns a disable mask and a target-processor number. Every source that is both pending and enabled is converted to a processor priority level through a fixed 32-entry source-to-level table. The resulting 15-bit level vector is delivered to exactly one processor, and every other processor receives zero from this unit. A separate per-processor block merges this vector with its own soft interrupts.

Software reaches the unit through a plain 32-bit register port addressed in words. The port is always ready. A write strobe is accepted on every clock edge where it is high, and there is no back-pressure. Reads are combinational from the registered state. Disabling a source also discards its pending record. The top bit of the mask acts as a global gate that stops all routing.

Top module: `irqm_router`

## Requirements
- R1: After reset the pending register reads 0, the target number reads 0, and the disable mask reads 0x4FB2007F.
- R2: Read word 0 returns the pending register with bit 31 forced to 0. Read word 1 returns the disable mask. Read word 4 returns the target number zero-extended. Words 2, 3, 5, 6 and 7 read as 0.
- R3: A write to word 2 clears, in the disable mask, every bit that is set in (data AND NOT 0x4FB2007F). This enables those sources.
- R4: A write to word 3 sets the bits of (data AND NOT 0x4FB2007F) in the disable mask and clears the same bits in the pending register. When a source rises in the same cycle, the clear takes precedence.
- R5: Bits set in 0x4FB2007F never change in the disable mask through any write.
- R6: A write to word 4 stores data bits 3:0 as the target number. All other data bits are dropped.
- R7: A rising edge on source n sets pending bit n, and a falling edge clears it. A source whose table level is 0 never becomes pending. In the default table these are bits 0-6, 16, 17, 20, 21, 23-27, 30 and 31.
- R8: The routed vector is the OR, over all bits that are pending and not disabled, of (1 << (level-1)). In the default table, bit n maps to level (n mod 15)+1 for every bit whose level is not 0.
- R9: While disable bit 31 is set, every processor's routed vector is 0, even if bits stay pending.
- R10: Only the processor whose index equals the target number receives a non-zero vector. The vector for processor c occupies cpu_levels[c*15 +: 15].
- R11: Writes and source edges take effect at the first clock edge after they are presented. The routed vector follows the registered state with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 32 | Device interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_levels | output | 240 | Routed level vector, 15 bits per processor |

## Verification
A wrong pending or disable bit reaches the ports at once. It shows in the read words, and on the target processor's slice as a level that is missing or extra, within the same cycle the state changes. A corrupted target number moves the whole vector to another processor's slice, so the bench compares every slice, not only the expected one. Edge-detection faults show only one cycle after a transition. For that reason the bench samples both before and after the edge, and it also tests a held-high line after a disable to confirm that no new request appears.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int SRC_N    = 32;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam logic [31:0] RESV_DEFAULT = 32'h4fb2_007f;

  typedef enum logic [ADDR_W-1:0] {
    W_PEND    = 3'd0,
    W_MASK    = 3'd1,
    W_ENABLE  = 3'd2,
    W_DISABLE = 3'd3,
    W_TARGET  = 3'd4
  } word_e;

  // Default source-to-level table: reserved lines, line 16 and the gate line map to 0.
  function automatic logic [SRC_N*4-1:0] default_map();
    logic [SRC_N*4-1:0] m;
    m = '0;
    for (int n = 0; n < SRC_N; n++) begin
      if (!RESV_DEFAULT[n] && n != 16 && n != 31)
        m[n*4 +: 4] = 4'((n % 15) + 1);
    end
    return m;
  endfunction
endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int              CPU_W     = 4,
  parameter logic [SRC_N-1:0] RESV_MASK = RESV_DEFAULT,
  parameter logic [SRC_N-1:0] ZERO_LVL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_irq,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [SRC_N-1:0]  pend_q,
  output logic [SRC_N-1:0]  dis_q,
  output logic [CPU_W-1:0]  tgt_q
);
  logic [SRC_N-1:0] src_q;
  logic [SRC_N-1:0] rise, fall, wmask;
  logic [SRC_N-1:0] pend_d, dis_d;
  logic [CPU_W-1:0] tgt_d;
  logic             hit_en, hit_dis, hit_tgt;

  assign rise    = src_irq & ~src_q & ~ZERO_LVL;
  assign fall    = ~src_irq & src_q;
  assign wmask   = bus_wdata[SRC_N-1:0] & ~RESV_MASK;
  assign hit_en  = bus_wr && (bus_addr == W_ENABLE);
  assign hit_dis = bus_wr && (bus_addr == W_DISABLE);
  assign hit_tgt = bus_wr && (bus_addr == W_TARGET);

  always_comb begin
    pend_d = (pend_q | rise) & ~fall;
    dis_d  = dis_q;
    tgt_d  = tgt_q;
    if (hit_en)  dis_d = dis_q & ~wmask;
    if (hit_dis) begin
      dis_d  = dis_q | wmask;
      pend_d = pend_d & ~wmask;   // software discard wins over a same-cycle rise
    end
    if (hit_tgt) tgt_d = bus_wdata[CPU_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      dis_q  <= RESV_MASK;
      tgt_q  <= '0;
    end else begin
      src_q  <= src_irq;
      pend_q <= pend_d;
      dis_q  <= dis_d;
      tgt_q  <= tgt_d;
    end
  end
endmodule

// File: rtl/irqm_level_map.sv
module irqm_level_map
  import irqm_pkg::*;
#(
  parameter int                      MAP_BITS  = 4,
  parameter logic [SRC_N*MAP_BITS-1:0] LEVEL_MAP = '0,
  localparam int                     LVL_N     = (1 << MAP_BITS) - 1
) (
  input  logic [SRC_N-1:0] active,
  output logic [LVL_N-1:0] levels
);
  function automatic logic [SRC_N-1:0] sources_at(input int lvl);
    logic [SRC_N-1:0] s;
    s = '0;
    for (int n = 0; n < SRC_N; n++)
      if (int'(LEVEL_MAP[n*MAP_BITS +: MAP_BITS]) == lvl) s[n] = 1'b1;
    return s;
  endfunction

  for (genvar k = 1; k <= LVL_N; k++) begin : g_lvl
    localparam logic [SRC_N-1:0] HITS = sources_at(k);
    assign levels[k-1] = |(active & HITS);
  end
endmodule

// File: rtl/irqm_fanout.sv
module irqm_fanout #(
  parameter int NUM_CPU = 16,
  parameter int LVL_N   = 15,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [LVL_N-1:0]         levels,
  input  logic                     gate_off,
  input  logic [CPU_W-1:0]         tgt,
  output logic [NUM_CPU*LVL_N-1:0] cpu_levels
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign cpu_levels[c*LVL_N +: LVL_N] =
      (!gate_off && tgt == CPU_W'(c)) ? levels : '0;
  end
endmodule

// File: rtl/irqm_router.sv
module irqm_router
  import irqm_pkg::*;
#(
  parameter int                    NUM_CPU   = 16,
  parameter int                    MAP_BITS  = 4,
  parameter logic [SRC_N-1:0]       RESV_MASK = RESV_DEFAULT,
  parameter logic [SRC_N*MAP_BITS-1:0] LEVEL_MAP = default_map(),
  localparam int                   LVL_N     = (1 << MAP_BITS) - 1,
  localparam int                   CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SRC_N-1:0]         src_irq,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_CPU*LVL_N-1:0] cpu_levels
);
  function automatic logic [SRC_N-1:0] zero_lines();
    logic [SRC_N-1:0] z;
    for (int n = 0; n < SRC_N; n++)
      z[n] = (LEVEL_MAP[n*MAP_BITS +: MAP_BITS] == '0);
    return z;
  endfunction
  localparam logic [SRC_N-1:0] ZERO_LVL = zero_lines();

  logic [SRC_N-1:0] pend_q, dis_q;
  logic [CPU_W-1:0] tgt_q;
  logic [LVL_N-1:0] levels;

  irqm_regs #(
    .CPU_W(CPU_W), .RESV_MASK(RESV_MASK), .ZERO_LVL(ZERO_LVL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q)
  );

  irqm_level_map #(
    .MAP_BITS(MAP_BITS), .LEVEL_MAP(LEVEL_MAP)
  ) u_map (
    .active(pend_q & ~dis_q),
    .levels(levels)
  );

  irqm_fanout #(
    .NUM_CPU(NUM_CPU), .LVL_N(LVL_N)
  ) u_fanout (
    .levels(levels), .gate_off(dis_q[SRC_N-1]), .tgt(tgt_q),
    .cpu_levels(cpu_levels)
  );

  always_comb begin
    unique case (bus_addr)
      W_PEND:   bus_rdata = {1'b0, pend_q[SRC_N-2:0]};
      W_MASK:   bus_rdata = dis_q;
      W_TARGET: bus_rdata = {{(DATA_W-CPU_W){1'b0}}, tgt_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqm_router_chk.sv
module irqm_router_chk
  import irqm_pkg::*;
#(
  parameter int                    NUM_CPU   = 16,
  parameter int                    MAP_BITS  = 4,
  parameter logic [SRC_N-1:0]       RESV_MASK = RESV_DEFAULT,
  parameter logic [SRC_N*MAP_BITS-1:0] LEVEL_MAP = default_map(),
  localparam int                   LVL_N     = (1 << MAP_BITS) - 1,
  localparam int                   CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [SRC_N-1:0]         pend,
  input logic [SRC_N-1:0]         dis,
  input logic [CPU_W-1:0]         tgt,
  input logic [NUM_CPU*LVL_N-1:0] cpu_levels
);
  function automatic logic [SRC_N-1:0] silent();
    logic [SRC_N-1:0] z;
    for (int n = 0; n < SRC_N; n++)
      z[n] = (LEVEL_MAP[n*MAP_BITS +: MAP_BITS] == '0);
    return z;
  endfunction
  localparam logic [SRC_N-1:0] SILENT = silent();

  assert_rd_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == W_PEND) |-> (bus_rdata[DATA_W-1] == 1'b0));
  assert_rd_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > W_TARGET) |-> (bus_rdata == '0));
  assert_enable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_ENABLE) |=> ((dis & $past(bus_wdata & ~RESV_MASK)) == '0));
  assert_disable_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_DISABLE) |=> ((pend & $past(bus_wdata & ~RESV_MASK)) == '0));
  assert_resv_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis & RESV_MASK) == RESV_MASK);
  assert_target_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == W_TARGET) |=> (tgt == $past(bus_wdata[CPU_W-1:0])));
  assert_silent_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & SILENT) == '0);
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dis[SRC_N-1] |-> (cpu_levels == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_other_cpu_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt != CPU_W'(c)) |-> (cpu_levels[c*LVL_N +: LVL_N] == '0));
  end
endmodule

bind irqm_router irqm_router_chk #(
  .NUM_CPU(NUM_CPU), .MAP_BITS(MAP_BITS), .RESV_MASK(RESV_MASK), .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend_q), .dis(dis_q),
  .tgt(tgt_q), .cpu_levels(cpu_levels)
);

// File: tb/test_irqm_router.sv
module test_irqm_router;
  localparam int NCPU = 16;
  localparam int LV   = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       src_irq = '0;
  logic              bus_wr = 1'b0;
  logic [2:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCPU*LV-1:0] cpu_levels;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irqm_router i_irqm_router (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_levels(cpu_levels)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // expected slice only on cpu t, zero everywhere else
  task automatic chk_route(input string req, input int t, input logic [14:0] exp);
    logic [31:0] bad;
    bad = 0;
    for (int c = 0; c < NCPU; c++) begin
      if (c == t) chk(req, 32'(cpu_levels[c*LV +: LV]), 32'(exp));
      else if (cpu_levels[c*LV +: LV] != '0) bad = bad + 1;
    end
    chk({req, " other cpus quiet"}, bad, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_irq = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_rd("R1 pending", 3'd0, 32'h0);
    chk_rd("R1 mask", 3'd1, 32'h4fb2007f);
    chk_rd("R1 target", 3'd4, 32'h0);
    chk_route("R1 outputs", 0, 15'h0);
  endtask

  task automatic t_read_map();
    chk_rd("R2 word2", 3'd2, 32'h0);
    chk_rd("R2 word3", 3'd3, 32'h0);
    chk_rd("R2 word5", 3'd5, 32'h0);
    chk_rd("R2 word7", 3'd7, 32'h0);
  endtask

  task automatic t_route_and_latency();
    @(negedge clk);
    src_irq[7] = 1'b1;
    #1;
    chk_route("R11 before edge", 0, 15'h0);
    @(negedge clk);
    chk_route("R8 line7 level8", 0, 15'h0080);
    chk_rd("R7 pending set", 3'd0, 32'h80);
  endtask

  task automatic t_disable_drops();
    wr(3'd3, 32'h80);
    chk_rd("R4 pending cleared", 3'd0, 32'h0);
    chk_rd("R4 mask set", 3'd1, 32'h4fb200ff);
    chk_route("R4 route off", 0, 15'h0);
    wr(3'd2, 32'h80);
    chk_rd("R3 mask cleared", 3'd1, 32'h4fb2007f);
    chk_rd("R4 held line no repend", 3'd0, 32'h0);
    set_src(32'h0);
    set_src(32'h80);
    chk_rd("R7 new rise", 3'd0, 32'h80);
    set_src(32'h0);
    chk_rd("R7 fall clears", 3'd0, 32'h0);
  endtask

  task automatic t_reserved();
    wr(3'd2, 32'hffffffff);
    chk_rd("R5 enable all", 3'd1, 32'h4fb2007f);
    wr(3'd3, 32'hffffffff);
    chk_rd("R5 disable all", 3'd1, 32'hffffffff);
    wr(3'd2, 32'hb04dff80);
    chk_rd("R3 reenable", 3'd1, 32'h4fb2007f);
  endtask

  task automatic t_target();
    wr(3'd4, 32'hfffffff5);
    chk_rd("R6 low bits", 3'd4, 32'h5);
    set_src(32'h100);
    chk_route("R10 cpu5", 5, 15'h0100);
    wr(3'd4, 32'h3);
    chk_route("R10 cpu3", 3, 15'h0100);
    set_src(32'h0);
    chk_route("R7 fall removes", 3, 15'h0);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_silent();
    set_src(32'h0001_0008);
    chk_rd("R7 level0 ignored", 3'd0, 32'h0);
    chk_route("R7 level0 no route", 0, 15'h0);
    set_src(32'h0);
  endtask

  task automatic t_gate();
    set_src(32'h200);
    chk_route("R8 line9 level10", 0, 15'h0200);
    wr(3'd3, 32'h80000000);
    chk_route("R9 gate closed", 0, 15'h0);
    chk_rd("R9 pending kept", 3'd0, 32'h200);
    wr(3'd2, 32'h80000000);
    chk_route("R9 gate open", 0, 15'h0200);
    set_src(32'h0);
  endtask

  task automatic t_shared();
    set_src(32'h0040_4080);
    chk_route("R8 shared level", 0, 15'h4080);
    wr(3'd3, 32'h0040_0000);
    chk_route("R8 one of pair off", 0, 15'h4080);
    wr(3'd3, 32'h80);
    chk_route("R8 pair off", 0, 15'h4000);
    wr(3'd2, 32'h0040_0080);
    set_src(32'h0);
  endtask

  task automatic t_collision();
    @(negedge clk);
    src_irq[28] = 1'b1;
    bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h1000_0000;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    chk_rd("R4 clear beats rise", 3'd0, 32'h0);
    wr(3'd2, 32'h1000_0000);
    set_src(32'h0);
    set_src(32'h1000_0000);
    chk_route("R8 line28 level14", 0, 15'h2000);
    set_src(32'h0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_map();
    t_route_and_latency();
    t_disable_drops();
    t_reserved();
    t_target();
    t_silent();
    t_gate();
    t_shared();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule